// File: doc/BRIEF.md
# Frame-Boundary Double-Buffered Window Configuration Bank

This block keeps two copies of the configuration words for a set of display windows. Software writes the pending copy at any time through a simple register port. The live copy drives the display pipeline, and it changes only at the start of a frame. A window's live words are reloaded from its pending words only when an update has been requested for that window and the window is not protected. A group of related register writes therefore reaches the pipeline as one change, even if the writes span a frame boundary.

Each window has a protect bit in a control word. Software sets it, rewrites the window's fields, then clears it. An update-request bit in the same control word arms a transfer for every window. Each window remembers its own armed state. An unprotected window transfers at the next rising edge of the vertical sync input and then drops its armed state. A protected window stays armed and transfers at the first rising edge after its protect bit is cleared, with no new request needed. The update-request bit reads back as set until every armed window has transferred. A second read port returns the live copy so that the applied state can be inspected.

Top module: `vsync_shadow_bank`

## Requirements
- R1: After reset, every pending word, every live word, all protect bits and all armed states are zero, so `act_cfg`, `win_en`, `rd_data` and `dbg_data` read zero.
- R2: A write to window word address `w*REGS_PER_WIN + r` changes the pending word, which `rd_data` returns at that address from the next cycle. The live copy does not change on a write.
- R3: A transfer happens only in the clock cycle in which vsync is first sampled high after being sampled low. The loaded live words appear on `act_cfg` and `dbg_data` from the following cycle. While vsync is held high there is no further transfer.
- R4: A vsync rising edge with no window armed leaves the live copy unchanged.
- R5: A window whose protect bit is 1 in the edge cycle keeps its live words and stays armed. It transfers at the first rising edge after its protect bit is cleared, with no new request.
- R6: Bit `DATA_W-1` of the control word reads 1 while any window is armed. It clears by itself once every armed window has transferred.
- R7: `win_en[w]` is bit `EN_BIT` of window w's live word 0. Clearing the pending enable turns the output off only at a transfer.
- R8: The control word sits at address `NUM_WIN*REGS_PER_WIN`, with the protect bits at `[NUM_WIN-1:0]` and the update request at bit `DATA_W-1`. Writing 1 to the request bit arms all windows. Writing 0 to it does not disarm anything.
- R9: `dbg_data` returns the live word at `dbg_addr`. Both read ports return zero for addresses above the control word, and writes to such addresses have no effect.
- R10: A write in the same cycle as a transfer edge updates the pending word. The live copy takes the value held before that write, and protect or request changes in that write apply only from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | Vertical sync level; a rising edge marks the frame boundary |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address for pending words and the control word |
| rd_data | output | DATA_W | Pending word or control word (combinational) |
| dbg_addr | input | ADDR_W | Read address for live words |
| dbg_data | output | DATA_W | Live word (combinational) |
| act_cfg | output | NUM_WIN*REGS_PER_WIN*DATA_W | All live words; word i at bits `[i*DATA_W +: DATA_W]` |
| win_en | output | NUM_WIN | Live enable bit of each window |

## Verification
The bench targets four corner cases.

- **Vsync held high for several cycles.** A design that detects the level rather than the edge would reload on every cycle, so writes made during the high phase would leak onto the live outputs.
- **Protected window.** A design that clears a single global request at the first edge would strand the protected window's pending words after unprotect. A design that ignores protect would expose a half-written window.
- **Write in the transfer cycle.** Some writes land in the same cycle as the transfer edge. A design that forwards the incoming write into the live copy would show the new value a frame early.
- **Writing 0 to the request bit.** A design that treats this as a disarm would drop a pending transfer.

Long random runs of writes and vsync toggles are compared every cycle against a behavioural model.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
   // Class of a register address: a window word, the control word, or unmapped
   typedef enum logic [1:0] {
      ASEL_WIN  = 2'd0,
      ASEL_CTRL = 2'd1,
      ASEL_NONE = 2'd2
   } addr_sel_e;

   function automatic addr_sel_e classify(input int unsigned addr, input int unsigned n_words);
      if (addr < n_words)       return ASEL_WIN;
      else if (addr == n_words) return ASEL_CTRL;
      else                      return ASEL_NONE;
   endfunction
endpackage

// File: rtl/vsb_vsync_edge.sv
module vsb_vsync_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync_i,
   output logic rise_o
);
   logic vs_s;
   logic vs_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign vs_s = vsync_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (SYNC_STAGES == 1) chain_q <= vsync_i;
            else chain_q <= {chain_q[SYNC_STAGES-2:0], vsync_i};
         end
         assign vs_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vs_q <= 1'b0;
      else        vs_q <= vs_s;
   end

   assign rise_o = vs_s & ~vs_q;

   // R3: a frame-boundary pulse never lasts two cycles
   a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/vsb_ctrl.sv
module vsb_ctrl #(
   parameter int NUM_WIN = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_we,
   input  logic [NUM_WIN-1:0] prot_wdata,
   input  logic               arm_wdata,
   input  logic               rise_i,
   output logic [NUM_WIN-1:0] prot_o,
   output logic [NUM_WIN-1:0] pend_o,
   output logic [NUM_WIN-1:0] xfer_o
);
   logic [NUM_WIN-1:0] prot_q;
   logic [NUM_WIN-1:0] pend_q;
   logic               arm;

   assign arm    = ctrl_we & arm_wdata;
   assign xfer_o = {NUM_WIN{rise_i}} & pend_q & ~prot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q <= '0;
         pend_q <= '0;
      end else begin
         if (ctrl_we) prot_q <= prot_wdata;
         pend_q <= (pend_q & ~xfer_o) | {NUM_WIN{arm}};
      end
   end

   assign prot_o = prot_q;
   assign pend_o = pend_q;

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
         // R6: an armed window that transfers drops its armed state
         a_r6_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (xfer_o[w] && !arm) |=> !pend_o[w]);
         // R5: a protected window keeps its armed state across an edge
         a_r5_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_i && pend_o[w] && prot_o[w]) |=> pend_o[w]);
      end
   endgenerate

   // R8: without a request and without an edge, the armed set does not change
   a_r8_no_disarm: assert property (@(posedge clk) disable iff (!rst_n)
      (!arm && !rise_i) |=> (pend_o == $past(pend_o)));
endmodule

// File: rtl/vsb_window.sv
module vsb_window #(
   parameter int REGS   = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W = (REGS > 1) ? $clog2(REGS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDX_W-1:0]       widx,
   input  logic [DATA_W-1:0]      wdata,
   input  logic                   xfer_i,
   output logic [REGS*DATA_W-1:0] front_o,
   output logic [REGS*DATA_W-1:0] act_o
);
   generate
      for (genvar r = 0; r < REGS; r++) begin : g_word
         logic [DATA_W-1:0] front_q;
         logic [DATA_W-1:0] act_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             front_q <= '0;
            else if (we && widx == IDX_W'(r))       front_q <= wdata;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      act_q <= '0;
            else if (xfer_i) act_q <= front_q;
         end

         assign front_o[r*DATA_W +: DATA_W] = front_q;
         assign act_o[r*DATA_W +: DATA_W]   = act_q;
      end
   endgenerate

   // R3, R10: a transfer loads the pending words held before the edge
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_i |=> (act_o == $past(front_o)));
   // R4: live words hold whenever there is no transfer
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_i |=> $stable(act_o));
endmodule

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank #(
   parameter int NUM_WIN      = 2,
   parameter int REGS_PER_WIN = 4,
   parameter int DATA_W       = 32,
   parameter int EN_BIT       = 0,
   parameter int SYNC_STAGES  = 0,
   localparam int NUM_REGS    = NUM_WIN * REGS_PER_WIN,
   localparam int ADDR_W      = $clog2(NUM_REGS + 1),
   localparam int IDX_W       = (REGS_PER_WIN > 1) ? $clog2(REGS_PER_WIN) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       vsync,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [ADDR_W-1:0]          rd_addr,
   output logic [DATA_W-1:0]          rd_data,
   input  logic [ADDR_W-1:0]          dbg_addr,
   output logic [DATA_W-1:0]          dbg_data,
   output logic [NUM_REGS*DATA_W-1:0] act_cfg,
   output logic [NUM_WIN-1:0]         win_en
);
   import vsb_pkg::*;

   localparam int UPD_BIT = DATA_W - 1;

   generate
      if (NUM_WIN < 1 || NUM_WIN >= UPD_BIT)
         $error("NUM_WIN must leave room for the request bit");
      if (REGS_PER_WIN < 1)
         $error("REGS_PER_WIN must be at least 1");
      if (EN_BIT < 0 || EN_BIT >= DATA_W)
         $error("EN_BIT outside the data word");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3)
         $error("SYNC_STAGES must be 0..3");
   endgenerate

   logic                       rise;
   logic                       ctrl_we;
   logic [NUM_WIN-1:0]         prot;
   logic [NUM_WIN-1:0]         pend;
   logic [NUM_WIN-1:0]         xfer;
   logic [NUM_REGS*DATA_W-1:0] front_all;
   logic [DATA_W-1:0]          ctrl_word;

   vsb_vsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .rise_o(rise)
   );

   assign ctrl_we = wr_en && (classify(int'(wr_addr), NUM_REGS) == ASEL_CTRL);

   vsb_ctrl #(.NUM_WIN(NUM_WIN)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we),
      .prot_wdata(wr_data[NUM_WIN-1:0]), .arm_wdata(wr_data[UPD_BIT]),
      .rise_i(rise), .prot_o(prot), .pend_o(pend), .xfer_o(xfer)
   );

   generate
      for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
         localparam int BASE = w * REGS_PER_WIN;
         logic              hit;
         logic [ADDR_W-1:0] off;

         assign hit = wr_en && (int'(wr_addr) >= BASE) && (int'(wr_addr) < BASE + REGS_PER_WIN);
         assign off = wr_addr - ADDR_W'(BASE);

         vsb_window #(.REGS(REGS_PER_WIN), .DATA_W(DATA_W)) u_win (
            .clk(clk), .rst_n(rst_n), .we(hit), .widx(IDX_W'(off)),
            .wdata(wr_data), .xfer_i(xfer[w]),
            .front_o(front_all[BASE*DATA_W +: REGS_PER_WIN*DATA_W]),
            .act_o(act_cfg[BASE*DATA_W +: REGS_PER_WIN*DATA_W])
         );

         assign win_en[w] = act_cfg[BASE*DATA_W + EN_BIT];

         // R5: a window protected in the edge cycle keeps its live words
         a_r5_protect_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            prot[w] |=> $stable(act_cfg[BASE*DATA_W +: REGS_PER_WIN*DATA_W]));
      end
   endgenerate

   always_comb begin
      ctrl_word = '0;
      ctrl_word[NUM_WIN-1:0] = prot;
      ctrl_word[UPD_BIT]     = |pend;
   end

   always_comb begin
      rd_data  = '0;
      dbg_data = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == ADDR_W'(i))  rd_data  = front_all[i*DATA_W +: DATA_W];
         if (dbg_addr == ADDR_W'(i)) dbg_data = act_cfg[i*DATA_W +: DATA_W];
      end
      if (rd_addr == ADDR_W'(NUM_REGS)) rd_data = ctrl_word;
   end

   // R6: the request bit reads set whenever some window is armed
   a_r6_req_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(NUM_REGS)) |-> (rd_data[UPD_BIT] == (pend != '0)));
   // R9: unmapped live-copy reads return zero
   a_r9_dbg_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(dbg_addr) > NUM_REGS) |-> (dbg_data == '0));
endmodule

// File: tb/vsync_shadow_bank_test.sv
module vsync_shadow_bank_test;
   localparam int NW     = 2;
   localparam int NR     = 4;
   localparam int DW     = 32;
   localparam int NREGS  = NW * NR;
   localparam int AW     = $clog2(NREGS + 1);
   localparam int CTRL   = NREGS;
   localparam int UPD    = DW - 1;
   localparam real HALF  = 4.0;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              vsync = 1'b0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [DW-1:0]     wr_data = '0;
   logic [AW-1:0]     rd_addr = '0;
   logic [DW-1:0]     rd_data;
   logic [AW-1:0]     dbg_addr = '0;
   logic [DW-1:0]     dbg_data;
   logic [NREGS*DW-1:0] act_cfg;
   logic [NW-1:0]     win_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(HALF) clk = ~clk;

   vsync_shadow_bank #(.NUM_WIN(NW), .REGS_PER_WIN(NR), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .vsync(vsync), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .dbg_addr(dbg_addr),
      .dbg_data(dbg_data), .act_cfg(act_cfg), .win_en(win_en)
   );

   // Behavioural reference model
   logic [DW-1:0] m_front [NREGS];
   logic [DW-1:0] m_act   [NREGS];
   logic [NW-1:0] m_prot;
   logic [NW-1:0] m_pend;
   logic          m_vs;

   task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] m_rd(input int a);
      logic [DW-1:0] v;
      v = '0;
      if (a < NREGS) v = m_front[a];
      else if (a == CTRL) begin
         v[NW-1:0] = m_prot;
         v[UPD]    = (m_pend != '0);
      end
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) begin m_front[i] = '0; m_act[i] = '0; end
         m_prot = '0; m_pend = '0; m_vs = 1'b0;
      end else begin
         logic [NW-1:0] keep;
         keep = m_pend;
         if (vsync && !m_vs) begin
            for (int w = 0; w < NW; w++)
               if (m_pend[w] && !m_prot[w]) begin
                  for (int r = 0; r < NR; r++) m_act[w*NR+r] = m_front[w*NR+r];
                  keep[w] = 1'b0;
               end
         end
         if (wr_en) begin
            if (int'(wr_addr) < NREGS) m_front[wr_addr] = wr_data;
            else if (int'(wr_addr) == CTRL) begin
               m_prot = wr_data[NW-1:0];
               if (wr_data[UPD]) keep = '1;
            end
         end
         m_pend = keep;
         m_vs   = vsync;
      end
   end

   // Per-cycle comparison, 2 ns after the edge
   always @(posedge clk) begin
      #2;
      if (!done) begin
         chk("R2 pending read", rd_data, m_rd(int'(rd_addr)));
         chk("R9 live read", dbg_data, (int'(dbg_addr) < NREGS) ? m_act[dbg_addr] : '0);
         for (int w = 0; w < NW; w++)
            chk("R7 enable", DW'(win_en[w]), DW'(m_act[w*NR][0]));
         for (int i = 0; i < NREGS; i++)
            chk("R3 live word", act_cfg[i*DW +: DW], m_act[i]);
      end
   end

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic vs_pulse(input int len);
      @(negedge clk);
      vsync = 1'b1;
      repeat (len) @(negedge clk);
      vsync = 1'b0;
      @(negedge clk);
   endtask

   task automatic peek(input int a, output logic [DW-1:0] d);
      rd_addr = AW'(a);
      #1 d = rd_data;
   endtask

   task automatic peek_live(input int a, output logic [DW-1:0] d);
      dbg_addr = AW'(a);
      #1 d = dbg_data;
   endtask

   initial begin
      #(HALF * 2.0 * 100000.0);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hung expected finish");
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 win_en", DW'(win_en), '0);
      peek(CTRL, d);  chk("R1 ctrl", d, '0);
      peek_live(1, d); chk("R1 live", d, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: write pending words, live copy untouched
      wr(0, 32'h0000_0001); wr(1, 32'h1111_1111); wr(2, 32'h2222_2222);
      wr(4, 32'h0000_0001); wr(6, 32'h6666_6666);
      peek(1, d); chk("R2 front", d, 32'h1111_1111);
      chk("R2 live untouched", DW'(win_en), '0);

      // R4: edge with nothing armed
      vs_pulse(2);
      chk("R4 no arm", DW'(win_en), '0);

      // R6, R3: arm and transfer with vsync held high
      wr(CTRL, 32'h8000_0000);
      peek(CTRL, d); chk("R6 armed", d, 32'h8000_0000);
      @(negedge clk); vsync = 1'b1;
      @(negedge clk);
      chk("R3 transfer", DW'(win_en), 32'h3);
      peek(CTRL, d); chk("R6 self clear", d, '0);
      peek_live(6, d); chk("R9 live word", d, 32'h6666_6666);
      // R3: vsync still high, armed write must not leak
      wr(2, 32'hAAAA_0002); wr(CTRL, 32'h8000_0000);
      repeat (3) @(negedge clk);
      peek_live(2, d); chk("R3 level no reload", d, 32'h2222_2222);
      vsync = 1'b0;
      vs_pulse(1);
      peek_live(2, d); chk("R3 next edge", d, 32'hAAAA_0002);

      // R5: protect window 1, arm, edge
      wr(CTRL, 32'h0000_0002);
      wr(5, 32'h5555_0005); wr(1, 32'h1111_0001);
      wr(CTRL, 32'h8000_0002);
      vs_pulse(1);
      peek_live(1, d); chk("R5 unprotected moves", d, 32'h1111_0001);
      peek_live(5, d); chk("R5 protected holds", d, '0);
      peek(CTRL, d); chk("R6 still armed", d, 32'h8000_0002);
      // R8: clearing protect with request bit 0 keeps window armed
      wr(CTRL, 32'h0000_0000);
      peek(CTRL, d); chk("R8 zero no disarm", d, 32'h8000_0000);
      vs_pulse(1);
      peek_live(5, d); chk("R5 after unprotect", d, 32'h5555_0005);
      peek(CTRL, d); chk("R6 cleared", d, '0);

      // R7: disable takes effect at the frame boundary
      wr(0, 32'h0); wr(CTRL, 32'h8000_0000);
      chk("R7 still on", DW'(win_en), 32'h3);
      vs_pulse(1);
      chk("R7 off", DW'(win_en), 32'h2);

      // R10: write in the edge cycle
      wr(CTRL, 32'h8000_0000);
      @(negedge clk);
      vsync = 1'b1; wr_en = 1'b1; wr_addr = AW'(3); wr_data = 32'hC0DE_0003;
      @(negedge clk);
      wr_en = 1'b0; vsync = 1'b0;
      @(negedge clk);
      peek_live(3, d); chk("R10 live old", d, '0);
      peek(3, d); chk("R10 front new", d, 32'hC0DE_0003);
      peek(CTRL, d); chk("R10 disarmed", d, '0);

      // R9: unmapped addresses
      wr(12, 32'hFFFF_FFFF);
      peek(12, d); chk("R9 unmapped rd", d, '0);
      peek_live(12, d); chk("R9 unmapped dbg", d, '0);

      // Random phase, checked every cycle against the model
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         wr_en   = ($urandom % 3) == 0;
         wr_addr = AW'($urandom % (NREGS + 3));
         wr_data = $urandom;
         if (($urandom % 5) == 0) vsync = ~vsync;
         rd_addr  = AW'($urandom % 16);
         dbg_addr = AW'($urandom % 16);
      end
      @(negedge clk);
      wr_en = 1'b0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule